// File: doc/BRIEF.md
# Next Program Counter Selector

This block owns the 32-bit program counter of a word-addressed processor core. On each clock where it is enabled, it loads one of four candidate addresses, chosen by a 2-bit select from the decoder. The candidates are the next sequential word, a PC-relative branch target, a jump inside the current 256 MB region, and a jump to an address held in a register. A branch only redirects the PC when the branch-taken condition is also true. Otherwise the PC steps forward by one word.

The block also drives the return address that jump-and-link instructions write back, which is the current PC plus 8. A register jump to an address that is not word aligned is refused: an alignment-error output is raised and the PC keeps its value.

All pins are plain control and data pins with no valid/ready handshake. The enable input is the only back-pressure: while it is low the PC holds, and the select and immediates are ignored.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset loads the PC with the parameter START_ADDR (default 32'hBFC0_0000) on the next rising clock edge.
- R2: While `en` is low, the PC keeps its value whatever the select, the branch condition and the operands are, and `align_err` stays low.
- R3: With `en` high and `sel` = 0, the PC becomes PC+4.
- R4: With `en` high, `sel` = 1 and `br_taken` high, the PC becomes PC+4 plus the sign-extended 16-bit offset shifted left by two, modulo 2^32.
- R5: With `en` high, `sel` = 1 and `br_taken` low, the PC becomes PC+4.
- R6: With `en` high and `sel` = 2, the PC becomes bits 31..28 of PC+4, followed by the 26-bit immediate, followed by two zero bits.
- R7: With `en` high, `sel` = 3 and `reg_target` bits 1..0 equal to zero, the PC becomes `reg_target`.
- R8: With `en` high, `sel` = 3 and `reg_target` bits 1..0 not zero, `align_err` is high in that same cycle and the PC is unchanged at the next edge. `align_err` is low in every other case.
- R9: `link_addr` always equals the current PC plus 8, modulo 2^32.
- R10: The region of a region jump comes from PC+4, not from PC. When the PC is the last word of a region, the jump lands in the following region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low stalls the PC |
| sel | input | 2 | Next-address source: 0 sequential, 1 branch, 2 region jump, 3 register jump |
| br_taken | input | 1 | Branch condition for select 1 |
| imm16 | input | 16 | Signed word offset for branches |
| imm26 | input | 26 | Word index for region jumps |
| reg_target | input | 32 | Register value for register jumps |
| pc_q | output | 32 | Current program counter |
| link_addr | output | 32 | Return address, PC+8 |
| align_err | output | 1 | Misaligned register-jump target refused |

## Verification
A behavioural model runs alongside the design, and the design's outputs are compared with it on every clock. Stimulus alternates between directed sequences and long pseudo-random runs.

The directed branches use offsets of +1, 0, -1 and the most negative value. These tell a correct sign extension and shift apart from a zero extension or a missing shift. Branches with the condition low show that the select alone does not redirect the PC.

Region jumps start from the last word of a region, which tells PC+4 apart from PC as the source of the region bits. Register jumps are tried with each of the four low-bit patterns, and some steps are stalled. Together these show that a refused jump, a stall and a normal load all leave different traces on `pc_q` and `align_err`.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_REGION = 2'd2,
    SRC_REG    = 2'd3
  } pc_src_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LINK_BYTES = 8;

endpackage

// File: rtl/pc_target_calc.sv
module pc_target_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIMM_W = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JIMM_W-1:0] imm26,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] link_addr,
  output logic [ADDR_W-1:0] branch_addr,
  output logic [ADDR_W-1:0] region_addr
);
  import pc_sequencer_pkg::*;

  localparam int unsigned EXT_W    = ADDR_W - IMM_W - 2;
  localparam int unsigned REGION_W = ADDR_W - JIMM_W - 2;

  logic [ADDR_W-1:0] offset_bytes;

  // Sign-extended word offset turned into a byte offset.
  assign offset_bytes = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};

  assign seq_addr    = pc + ADDR_W'(WORD_BYTES);
  assign link_addr   = pc + ADDR_W'(LINK_BYTES);
  assign branch_addr = seq_addr + offset_bytes;

  // The region bits come from the address after the jump, not the jump itself.
  assign region_addr = {seq_addr[ADDR_W-1 -: REGION_W], imm26, 2'b00};

endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux #(
  parameter int unsigned ADDR_W      = 32,
  parameter bit          ALIGN_CHECK = 1'b1
) (
  input  logic              en,
  input  logic [1:0]        sel,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] branch_addr,
  input  logic [ADDR_W-1:0] region_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic              load,
  output logic [ADDR_W-1:0] next_addr,
  output logic              misaligned
);
  import pc_sequencer_pkg::*;

  pc_src_e src;
  logic    bad_low;

  assign src = pc_src_e'(sel);

  generate
    if (ALIGN_CHECK) begin : g_align
      assign bad_low = |reg_addr[1:0];
    end else begin : g_noalign
      assign bad_low = 1'b0;
    end
  endgenerate

  always_comb begin
    next_addr  = seq_addr;
    misaligned = 1'b0;
    unique case (src)
      SRC_SEQ:    next_addr = seq_addr;
      SRC_BRANCH: next_addr = br_taken ? branch_addr : seq_addr;
      SRC_REGION: next_addr = region_addr;
      SRC_REG: begin
        next_addr  = reg_addr;
        misaligned = bad_low;
      end
      default:    next_addr = seq_addr;
    endcase
    misaligned = misaligned & en;
    load       = en & ~misaligned;
  end

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= START_ADDR;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int unsigned        ADDR_W      = 32,
  parameter int unsigned        IMM_W       = 16,
  parameter int unsigned        JIMM_W      = 26,
  parameter bit                 ALIGN_CHECK = 1'b1,
  parameter logic [ADDR_W-1:0]  START_ADDR  = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        sel,
  input  logic              br_taken,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JIMM_W-1:0] imm26,
  input  logic [ADDR_W-1:0] reg_target,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] link_addr,
  output logic              align_err
);

  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] branch_addr;
  logic [ADDR_W-1:0] region_addr;
  logic [ADDR_W-1:0] next_addr;
  logic              load;

  pc_target_calc #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .JIMM_W (JIMM_W)
  ) u_calc (
    .pc          (pc_q),
    .imm16       (imm16),
    .imm26       (imm26),
    .seq_addr    (seq_addr),
    .link_addr   (link_addr),
    .branch_addr (branch_addr),
    .region_addr (region_addr)
  );

  pc_next_mux #(
    .ADDR_W      (ADDR_W),
    .ALIGN_CHECK (ALIGN_CHECK)
  ) u_mux (
    .en          (en),
    .sel         (sel),
    .br_taken    (br_taken),
    .seq_addr    (seq_addr),
    .branch_addr (branch_addr),
    .region_addr (region_addr),
    .reg_addr    (reg_target),
    .load        (load),
    .next_addr   (next_addr),
    .misaligned  (align_err)
  );

  pc_reg #(
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR)
  ) u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (next_addr),
    .q    (pc_q)
  );

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        IMM_W      = 16,
  parameter int unsigned        JIMM_W     = 26,
  parameter logic [ADDR_W-1:0]  START_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [1:0]        sel,
  input logic              br_taken,
  input logic [IMM_W-1:0]  imm16,
  input logic [JIMM_W-1:0] imm26,
  input logic [ADDR_W-1:0] reg_target,
  input logic [ADDR_W-1:0] pc_q,
  input logic              align_err
);
  localparam int unsigned LOW_W = JIMM_W + 2;

  // R1
  reset_start_chk: assert property (@(posedge clk) rst |=> (pc_q == START_ADDR));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc_q));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel == 2'd0) |=> (pc_q == $past(pc_q) + ADDR_W'(4)));

  // R5
  untaken_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel == 2'd1 && !br_taken) |=> (pc_q == $past(pc_q) + ADDR_W'(4)));

  // R6
  region_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel == 2'd2) |=> (pc_q[LOW_W-1:0] == {$past(imm26), 2'b00}));

  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel == 2'd3 && reg_target[1:0] == 2'b00) |=> (pc_q == $past(reg_target)));

  // R8
  misalign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |=> $stable(pc_q));

  // R8
  misalign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |-> (en && sel == 2'd3));

endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W     (ADDR_W),
  .IMM_W      (IMM_W),
  .JIMM_W     (JIMM_W),
  .START_ADDR (START_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .sel        (sel),
  .br_taken   (br_taken),
  .imm16      (imm16),
  .imm26      (imm26),
  .reg_target (reg_target),
  .pc_q       (pc_q),
  .align_err  (align_err)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;

  localparam logic [31:0] START = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        br_taken = 1'b0;
  logic [15:0] imm16 = '0;
  logic [25:0] imm26 = '0;
  logic [31:0] reg_target = '0;
  logic [31:0] pc_q;
  logic [31:0] link_addr;
  logic        align_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model_pc;

  always #2.5 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rst(rst), .en(en), .sel(sel), .br_taken(br_taken),
    .imm16(imm16), .imm26(imm26), .reg_target(reg_target),
    .pc_q(pc_q), .link_addr(link_addr), .align_err(align_err)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input bit e, input logic [1:0] s, input bit b, input logic [31:0] r);
    if (!e) return "R2";
    case (s)
      2'd0: return "R3";
      2'd1: return b ? "R4" : "R5";
      2'd2: return "R6";
      default: return (r[1:0] != 2'b00) ? "R8" : "R7";
    endcase
  endfunction

  // One enabled or stalled step: drive on the falling edge, check after the next one.
  task automatic step(input bit e, input logic [1:0] s, input bit b,
                      input logic [15:0] i16, input logic [25:0] i26, input logic [31:0] r);
    logic [31:0] nxt;
    bit exp_err;
    string tag;
    en = e; sel = s; br_taken = b; imm16 = i16; imm26 = i26; reg_target = r;
    #0.5;
    exp_err = e && (s == 2'd3) && (r[1:0] != 2'b00);
    tag = req_of(e, s, b, r);
    check32(exp_err ? "R8" : (e ? "R8" : "R2"), {31'd0, align_err}, {31'd0, exp_err});
    check32("R9", link_addr, model_pc + 32'd8);
    nxt = model_pc;
    if (e) begin
      case (s)
        2'd0: nxt = model_pc + 32'd4;
        2'd1: nxt = b ? model_pc + 32'd4 + 32'($signed(i16) * 4) : model_pc + 32'd4;
        2'd2: nxt = ((model_pc + 32'd4) & 32'hF000_0000) | (32'(i26) * 4);
        default: nxt = exp_err ? model_pc : r;
      endcase
    end
    @(posedge clk);
    model_pc = nxt;
    @(negedge clk);
    check32(tag, pc_q, model_pc);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_pc = START;
    check32("R1", pc_q, START);
    check32("R9", link_addr, START + 32'd8);

    // R3 sequential, R2 stall with every select
    step(1, 2'd0, 0, 16'h0, 26'h0, 32'h0);
    step(0, 2'd1, 1, 16'h7FFF, 26'h0, 32'h0);
    step(0, 2'd3, 0, 16'h0, 26'h0, 32'h3);
    step(0, 2'd2, 0, 16'h0, 26'h3FFFFFF, 32'h0);
    // R4 branch offsets +1, 0, -1, most negative, most positive
    step(1, 2'd1, 1, 16'h0001, 26'h0, 32'h0);
    step(1, 2'd1, 1, 16'h0000, 26'h0, 32'h0);
    step(1, 2'd1, 1, 16'hFFFF, 26'h0, 32'h0);
    step(1, 2'd1, 1, 16'h8000, 26'h0, 32'h0);
    step(1, 2'd1, 1, 16'h7FFF, 26'h0, 32'h0);
    // R5 untaken branch
    step(1, 2'd1, 0, 16'h1234, 26'h0, 32'h0);
    // R7 and R8: every low-bit pattern
    step(1, 2'd3, 0, 16'h0, 26'h0, 32'h0FFF_FFFC);
    step(1, 2'd3, 0, 16'h0, 26'h0, 32'h1234_5671);
    step(1, 2'd3, 0, 16'h0, 26'h0, 32'h1234_5672);
    step(1, 2'd3, 0, 16'h0, 26'h0, 32'h1234_5673);
    // R10: PC is 0x0FFFFFFC, jump must land in region 1
    step(1, 2'd2, 0, 16'h0, 26'h0000010, 32'h0);
    check32("R10", pc_q, 32'h1000_0040);
    // R6 region jump with all-ones immediate
    step(1, 2'd2, 0, 16'h0, 26'h3FFFFFF, 32'h0);
    // R9 wrap of PC+8 near the top of the address space
    step(1, 2'd3, 0, 16'h0, 26'h0, 32'hFFFF_FFFC);
    step(1, 2'd0, 0, 16'h0, 26'h0, 32'h0);

    // Pseudo-random run
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(($urandom % 4) != 0, 2'($urandom), 1'($urandom), 16'($urandom),
           26'($urandom), rv);
    end

    // R1 reset in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_pc = START;
    check32("R1", pc_q, START);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule